// File: doc/BRIEF.md
# Zero-Padded Reference Row Band Buffer

This block keeps a horizontal band of previous-frame rows on chip so that a block-matching motion search can run over a whole row of blocks without returning to frame memory. When a fill is started for a block row, a sequencer walks the band buffer row by row. Each band row that maps onto a real frame row is fetched pixel by pixel from frame memory over a request/response port. Each band row that lies above or below the frame is written with zeros and generates no memory traffic.

Once the fill has completed, the search engine issues reads. A read names a block column, a pixel position inside the block and a signed candidate displacement. The block converts these into a band row and a frame column. If the column falls left or right of the frame, the result is zero. The pixel comes back one cycle after the read is accepted. Reads are refused while a fill is running. Band storage is a single-port array addressed as band row times frame width plus column.

Top module: `zpad_ref_band`

## Requirements
- R1: After reset, `rd_dv_o`, `fill_done_o` and `mreq_valid_o` are low and `rd_ready_o` is high.
- R2: A fill started with block row b requests every frame row from b*BLK-SRCH up to b*BLK+BLK+SRCH-1 that lies inside 0..FRM_ROWS-1. Rows are requested in ascending order, and within a row every column is requested from 0 to FRM_COLS-1 in ascending order.
- R3: Band rows whose frame row is negative or at least FRM_ROWS are never requested, and they read back as zero.
- R4: `fill_done_o` goes high for exactly one cycle after the last band pixel is written.
- R5: While a fill runs, `rd_ready_o` is low and a read request produces no result.
- R6: An accepted read returns `rd_dv_o` high one cycle later. The data is the frame pixel at row b*BLK+k+di and column c*BLK+l+dj, where b is the filled block row and c is the block column.
- R7: A read whose column c*BLK+l+dj is below 0 or at least FRM_COLS returns zero.
- R8: A memory request held without ready keeps its row and column unchanged until it is accepted.
- R9: A fill start pulse that arrives while a fill is running is ignored, and the band keeps the data of the first block row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fill_start_i | input | 1 | Start loading the band for a block row |
| fill_brow_i | input | BRW | Block row to load |
| fill_done_o | output | 1 | One-cycle pulse when the band is complete |
| mreq_valid_o | output | 1 | Frame memory request valid |
| mreq_ready_i | input | 1 | Frame memory accepts request |
| mreq_row_o | output | FRW | Requested frame row |
| mreq_col_o | output | CW | Requested frame column |
| mrsp_valid_i | input | 1 | Frame memory response valid |
| mrsp_data_i | input | PIX_W | Response pixel |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read can be accepted (low during fill) |
| rd_bcol_i | input | BCW | Block column |
| rd_k_i | input | KW | Pixel row inside the block |
| rd_l_i | input | KW | Pixel column inside the block |
| rd_di_i | input | DW | Signed vertical displacement |
| rd_dj_i | input | DW | Signed horizontal displacement |
| rd_dv_o | output | 1 | Read data valid |
| rd_data_o | output | PIX_W | Read pixel or zero |

## Verification
The assertions assume that every accepted read keeps its vertical displacement within ±SRCH, so the band row k+di+SRCH always lies inside the band. They also assume that frame memory returns exactly one response for each accepted request, and only while the sequencer is waiting for it. The bench frame-memory model answers each accepted request once, on the following cycle, and withholds ready on a regular pattern to exercise request holding. Read stimulus uses only displacements between -7 and +7 with in-block offsets, and drives reads during a fill only to observe that they are refused.

// File: rtl/zpad_ref_band_pkg.sv
package zpad_ref_band_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_ROWSEL,
    FS_REQ,
    FS_WAIT,
    FS_ZERO
  } fill_st_e;

  function automatic logic in_span(input int v, input int lim);
    return (v >= 0) && (v < lim);
  endfunction

endpackage

// File: rtl/zpad_fill_seq.sv
module zpad_fill_seq
  import zpad_ref_band_pkg::*;
#(
  parameter int BLK      = 16,
  parameter int SRCH     = 7,
  parameter int FRM_ROWS = 144,
  parameter int FRM_COLS = 176,
  parameter int PIX_W    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [((FRM_ROWS/BLK)>1 ? $clog2(FRM_ROWS/BLK) : 1)-1:0] brow_i,
  output logic                   mreq_valid_o,
  input  logic                   mreq_ready_i,
  output logic [$clog2(FRM_ROWS)-1:0] mreq_row_o,
  output logic [$clog2(FRM_COLS)-1:0] mreq_col_o,
  input  logic                   mrsp_valid_i,
  input  logic [PIX_W-1:0]       mrsp_data_i,
  output logic                   wr_en_o,
  output logic [$clog2(BLK+2*SRCH)-1:0] wr_row_o,
  output logic [$clog2(FRM_COLS)-1:0]   wr_col_o,
  output logic [PIX_W-1:0]       wr_data_o,
  output logic                   busy_o,
  output logic                   done_o
);

  localparam int NROW = BLK + 2*SRCH;
  localparam int RW   = $clog2(NROW);
  localparam int CW   = $clog2(FRM_COLS);
  localparam int FRW  = $clog2(FRM_ROWS);
  localparam int BW   = FRW + 2;

  fill_st_e             st_q, st_d;
  logic [RW-1:0]        r_q, r_d;
  logic [CW-1:0]        c_q, c_d;
  logic signed [BW-1:0] base_q, base_d;
  logic                 done_q, done_d;
  int                   frow;
  logic                 last_col, last_row;

  assign frow     = int'(base_q) + int'(r_q);
  assign last_col = (c_q == CW'(FRM_COLS-1));
  assign last_row = (r_q == RW'(NROW-1));

  always_comb begin
    st_d         = st_q;
    r_d          = r_q;
    c_d          = c_q;
    base_d       = base_q;
    done_d       = 1'b0;
    wr_en_o      = 1'b0;
    wr_data_o    = '0;
    mreq_valid_o = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (start_i) begin
          base_d = BW'(int'(brow_i) * BLK - SRCH);
          r_d    = '0;
          c_d    = '0;
          st_d   = FS_ROWSEL;
        end
      end
      FS_ROWSEL: begin
        st_d = in_span(frow, FRM_ROWS) ? FS_REQ : FS_ZERO;
      end
      FS_REQ: begin
        mreq_valid_o = 1'b1;
        if (mreq_ready_i) st_d = FS_WAIT;
      end
      FS_WAIT, FS_ZERO: begin
        if (st_q == FS_ZERO || mrsp_valid_i) begin
          wr_en_o   = 1'b1;
          wr_data_o = (st_q == FS_WAIT) ? mrsp_data_i : '0;
          if (last_col) begin
            c_d = '0;
            if (last_row) begin
              st_d   = FS_IDLE;
              done_d = 1'b1;
            end else begin
              r_d  = r_q + 1'b1;
              st_d = FS_ROWSEL;
            end
          end else begin
            c_d  = c_q + 1'b1;
            st_d = (st_q == FS_WAIT) ? FS_REQ : FS_ZERO;
          end
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      r_q    <= '0;
      c_q    <= '0;
      base_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      r_q    <= r_d;
      c_q    <= c_d;
      base_q <= base_d;
      done_q <= done_d;
    end
  end

  assign mreq_row_o = FRW'(frow);
  assign mreq_col_o = c_q;
  assign wr_row_o   = r_q;
  assign wr_col_o   = c_q;
  assign busy_o     = (st_q != FS_IDLE);
  assign done_o     = done_q;

  // R8: a stalled request keeps its address
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_valid_o && !mreq_ready_i) |=>
      (mreq_valid_o && $stable(mreq_row_o) && $stable(mreq_col_o)));

  // R3: only in-frame rows reach frame memory
  p_req_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_valid_o |-> in_span(frow, FRM_ROWS));

  // R4: done is a single-cycle pulse, seen once the sequencer is idle
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9: start outside idle leaves the band origin untouched
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(base_q));

endmodule

// File: rtl/zpad_rd_addr.sv
module zpad_rd_addr #(
  parameter int BLK      = 16,
  parameter int SRCH     = 7,
  parameter int FRM_COLS = 176
) (
  input  logic [((FRM_COLS/BLK)>1 ? $clog2(FRM_COLS/BLK) : 1)-1:0] bcol_i,
  input  logic [$clog2(BLK)-1:0]         k_i,
  input  logic [$clog2(BLK)-1:0]         l_i,
  input  logic signed [$clog2(SRCH+1):0] di_i,
  input  logic signed [$clog2(SRCH+1):0] dj_i,
  output logic [$clog2(BLK+2*SRCH)-1:0]  row_o,
  output logic [$clog2(FRM_COLS)-1:0]    col_o,
  output logic                           oob_o
);

  localparam int RW = $clog2(BLK + 2*SRCH);
  localparam int CW = $clog2(FRM_COLS);

  int brow_idx;
  int fcol;

  always_comb begin
    brow_idx = int'(k_i) + int'(di_i) + SRCH;
    fcol     = int'(bcol_i) * BLK + int'(l_i) + int'(dj_i);
    oob_o    = (fcol < 0) || (fcol >= FRM_COLS);
    row_o    = RW'(brow_idx);
    col_o    = oob_o ? '0 : CW'(fcol);
  end

endmodule

// File: rtl/zpad_store.sv
module zpad_store #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 5280
) (
  input  logic                     clk_i,
  input  logic                     en_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  input  logic [PIX_W-1:0]         wd_i,
  output logic [PIX_W-1:0]         q_o
);

  logic [PIX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wd_i;
      else      q_o           <= mem_q[addr_i];
    end
  end

endmodule

// File: rtl/zpad_ref_band.sv
module zpad_ref_band #(
  parameter int BLK      = 16,
  parameter int SRCH     = 7,
  parameter int FRM_ROWS = 144,
  parameter int FRM_COLS = 176,
  parameter int PIX_W    = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fill_start_i,
  input  logic [((FRM_ROWS/BLK)>1 ? $clog2(FRM_ROWS/BLK) : 1)-1:0] fill_brow_i,
  output logic                   fill_done_o,
  output logic                   mreq_valid_o,
  input  logic                   mreq_ready_i,
  output logic [$clog2(FRM_ROWS)-1:0] mreq_row_o,
  output logic [$clog2(FRM_COLS)-1:0] mreq_col_o,
  input  logic                   mrsp_valid_i,
  input  logic [PIX_W-1:0]       mrsp_data_i,
  input  logic                   rd_valid_i,
  output logic                   rd_ready_o,
  input  logic [((FRM_COLS/BLK)>1 ? $clog2(FRM_COLS/BLK) : 1)-1:0] rd_bcol_i,
  input  logic [$clog2(BLK)-1:0] rd_k_i,
  input  logic [$clog2(BLK)-1:0] rd_l_i,
  input  logic signed [$clog2(SRCH+1):0] rd_di_i,
  input  logic signed [$clog2(SRCH+1):0] rd_dj_i,
  output logic                   rd_dv_o,
  output logic [PIX_W-1:0]       rd_data_o
);

  localparam int NROW  = BLK + 2*SRCH;
  localparam int RW    = $clog2(NROW);
  localparam int CW    = $clog2(FRM_COLS);
  localparam int DEPTH = NROW * FRM_COLS;
  localparam int AW    = $clog2(DEPTH);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic             wr_en, busy;
  logic [RW-1:0]    wr_row, rd_row;
  logic [CW-1:0]    wr_col, rd_col;
  logic [PIX_W-1:0] wr_data, ram_q;
  logic             rd_oob, rd_fire;
  logic             ram_en;
  logic [AW-1:0]    ram_addr;
  logic             dv_q, oob_q;

  zpad_fill_seq #(
    .BLK(BLK), .SRCH(SRCH), .FRM_ROWS(FRM_ROWS), .FRM_COLS(FRM_COLS), .PIX_W(PIX_W)
  ) fill_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .start_i      (fill_start_i),
    .brow_i       (fill_brow_i),
    .mreq_valid_o (mreq_valid_o),
    .mreq_ready_i (mreq_ready_i),
    .mreq_row_o   (mreq_row_o),
    .mreq_col_o   (mreq_col_o),
    .mrsp_valid_i (mrsp_valid_i),
    .mrsp_data_i  (mrsp_data_i),
    .wr_en_o      (wr_en),
    .wr_row_o     (wr_row),
    .wr_col_o     (wr_col),
    .wr_data_o    (wr_data),
    .busy_o       (busy),
    .done_o       (fill_done_o)
  );

  zpad_rd_addr #(
    .BLK(BLK), .SRCH(SRCH), .FRM_COLS(FRM_COLS)
  ) radr_i (
    .bcol_i (rd_bcol_i),
    .k_i    (rd_k_i),
    .l_i    (rd_l_i),
    .di_i   (rd_di_i),
    .dj_i   (rd_dj_i),
    .row_o  (rd_row),
    .col_o  (rd_col),
    .oob_o  (rd_oob)
  );

  assign rd_ready_o = !busy;
  assign rd_fire    = rd_valid_i && rd_ready_o;
  assign ram_en     = wr_en || rd_fire;

  always_comb begin
    if (wr_en) ram_addr = AW'(int'(wr_row) * FRM_COLS + int'(wr_col));
    else       ram_addr = AW'(int'(rd_row) * FRM_COLS + int'(rd_col));
  end

  zpad_store #(.PIX_W(PIX_W), .DEPTH(DEPTH)) store_i (
    .clk_i  (clk_i),
    .en_i   (ram_en),
    .we_i   (wr_en),
    .addr_i (ram_addr),
    .wd_i   (wr_data),
    .q_o    (ram_q)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      oob_q <= 1'b0;
    end else begin
      dv_q <= rd_fire;
      if (rd_fire) oob_q <= rd_oob;
    end
  end

  assign rd_dv_o   = dv_q;
  assign rd_data_o = oob_q ? '0 : ram_q;

  // R5: no read accepted while the band is being loaded
  p_ready_low_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    mreq_valid_o |-> !rd_ready_o);
  p_no_port_clash_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en && rd_fire));

  // R6: one-cycle read latency, no spurious valid
  p_dv_after_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_fire |=> rd_dv_o);
  p_no_dv_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_fire |=> !rd_dv_o);
  p_rd_row_span_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_fire |-> ((int'(rd_k_i) + int'(rd_di_i) + SRCH) >= 0 &&
                 (int'(rd_k_i) + int'(rd_di_i) + SRCH) < NROW));

  // R7: a horizontally outside pixel reads as zero
  p_oob_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_fire && rd_oob) |=> (rd_data_o == '0));

  // R1: quiet outputs right after reset release
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_n |-> (!rd_dv_o && !fill_done_o && !mreq_valid_o));

endmodule

// File: tb/zpad_ref_band_tb.sv
module zpad_ref_band_tb_top;

  localparam int BLK = 16, SRCH = 7, FR = 144, FC = 176, NROW = BLK + 2*SRCH;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic fill_start_i;
  logic [3:0] fill_brow_i;
  logic fill_done_o, mreq_valid_o, mreq_ready_i, mrsp_valid_i;
  logic [7:0] mreq_row_o, mreq_col_o, mrsp_data_i;
  logic rd_valid_i, rd_ready_o, rd_dv_o;
  logic [3:0] rd_bcol_i, rd_k_i, rd_l_i;
  logic signed [3:0] rd_di_i, rd_dj_i;
  logic [7:0] rd_data_o;

  always #4 clk_i = ~clk_i;

  zpad_ref_band dut_i (.*);

  int total = 0, bad = 0;
  bit ended = 0;
  int req_cnt, req_bad, er, ec;
  int exp_q[$];
  string tag_q[$];

  function automatic int pix(int r, int c);
    return ((r*13 + c*7 + 5) % 255) + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // frame memory model: accepts with periodic stalls, answers next cycle
  initial begin
    bit pend = 0;
    int pr = 0, pc = 0, cyc = 0;
    mreq_ready_i = 0; mrsp_valid_i = 0; mrsp_data_i = 0;
    forever begin
      @(negedge clk_i);
      cyc++;
      mrsp_valid_i = 0;
      if (pend) begin
        mrsp_valid_i = 1;
        mrsp_data_i  = 8'(pix(pr, pc));
        pend = 0;
      end
      mreq_ready_i = mreq_valid_o && (cyc % 3 != 1);
      if (mreq_ready_i) begin
        pr = int'(mreq_row_o); pc = int'(mreq_col_o);
        pend = 1;
        req_cnt++;
        if (pr != er || pc != ec) req_bad++;
        ec++;
        if (ec == FC) begin ec = 0; er++; end
      end
    end
  end

  // monitor: pop expected read results
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_dv_o) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected read data", int'(rd_data_o), -1);
        else begin
          int e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk(int'(rd_data_o) == e, t, int'(rd_data_o), e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic rd(int br, int bc, int k, int l, int di, int dj, string tag);
    int fr, col, e;
    @(negedge clk_i);
    rd_valid_i = 1;
    rd_bcol_i = 4'(bc); rd_k_i = 4'(k); rd_l_i = 4'(l);
    rd_di_i = 4'(di); rd_dj_i = 4'(dj);
    fr  = br*BLK + k + di;
    col = bc*BLK + l + dj;
    e = (fr < 0 || fr >= FR || col < 0 || col >= FC) ? 0 : pix(fr, col);
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic rd_end();
    @(negedge clk_i); rd_valid_i = 0;
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
  endtask

  task automatic do_fill(int br, bit poke);
    int lo, hi, nexp, w;
    lo = br*BLK - SRCH; hi = lo + NROW;
    if (lo < 0) lo = 0;
    if (hi > FR) hi = FR;
    nexp = (hi - lo) * FC;
    req_cnt = 0; req_bad = 0; er = lo; ec = 0;
    @(negedge clk_i); fill_start_i = 1; fill_brow_i = 4'(br);
    @(negedge clk_i); fill_start_i = 0;
    chk(rd_ready_o == 0, "R5 ready low in fill", int'(rd_ready_o), 0);
    if (poke) begin
      repeat (100) @(negedge clk_i);
      fill_start_i = 1; fill_brow_i = 4'(br == 1 ? 2 : 1);   // R9
      rd_valid_i = 1;                                        // R5
      @(negedge clk_i); fill_start_i = 0;
      chk(rd_ready_o == 0, "R5 ready low under read", int'(rd_ready_o), 0);
      @(negedge clk_i); rd_valid_i = 0;
    end
    w = 0;
    while (!fill_done_o && w < 60000) begin @(negedge clk_i); w++; end
    chk(fill_done_o == 1, "R4 done seen", int'(fill_done_o), 1);
    @(negedge clk_i);
    chk(fill_done_o == 0, "R4 done one cycle", int'(fill_done_o), 0);
    chk(req_cnt == nexp, "R2 request count", req_cnt, nexp);
    chk(req_bad == 0, "R2 R3 request order", req_bad, 0);
  endtask

  initial begin
    rst_ni = 0; fill_start_i = 0; fill_brow_i = 0; rd_valid_i = 0;
    rd_bcol_i = 0; rd_k_i = 0; rd_l_i = 0; rd_di_i = 0; rd_dj_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    chk(rd_dv_o == 0, "R1 dv", int'(rd_dv_o), 0);
    chk(fill_done_o == 0, "R1 done", int'(fill_done_o), 0);
    chk(mreq_valid_o == 0, "R1 mreq", int'(mreq_valid_o), 0);
    chk(rd_ready_o == 1, "R1 ready", int'(rd_ready_o), 1);

    // top band: rows above the frame are zero
    do_fill(0, 0);
    rd(0, 3, 0, 0, -7, 0, "R3 top pad row");
    rd(0, 3, 6, 2, -7, 1, "R3 top pad last");
    rd(0, 3, 0, 0, 0, 0, "R6 first frame row");
    rd(0, 5, 9, 4, 3, -2, "R6 mid");
    rd(0, 0, 0, 0, 0, -1, "R7 left col -1");
    rd(0, 0, 2, 0, 1, 0, "R7 left col 0");
    rd_end();

    // middle band with a stray start and read during fill
    do_fill(4, 1);
    rd(4, 5, 0, 0, -7, -7, "R9 band keeps row 4");
    rd(4, 10, 15, 15, 7, 0, "R7 right col last");
    rd(4, 10, 15, 15, 7, 1, "R7 right col over");
    rd(4, 10, 8, 9, 2, 7, "R7 right far");
    rd(4, 2, 7, 7, 4, 5, "R6 mid b4");
    rd(4, 7, 12, 3, -5, -6, "R6 neg disp");
    rd_end();

    // bottom band: rows below the frame are zero
    do_fill(8, 0);
    rd(8, 4, 15, 0, 7, 0, "R3 bottom pad");
    rd(8, 4, 15, 0, 0, 0, "R6 last frame row");
    rd(8, 4, 9, 5, 6, 3, "R3 bottom pad edge");
    rd(8, 0, 0, 3, -7, -3, "R6 top of band b8");
    rd_end();

    finish_run();
  end

endmodule